// File: doc/BRIEF.md
# Counter-Bound Pad Encryption Controller for Off-Chip Cache Lines

This block sits between a processor cache and an external memory and keeps every 256-bit cache line encrypted while it is off chip. Each line is combined by XOR with a keystream pad. The pad comes from an external pad generator, which is a block cipher that is not part of this project. The generator is fed a 128-bit seed. The seed packs a per-line write counter, the line index and a fixed padding constant. A line therefore never reuses a pad across writes, and a line copied to another address decrypts to garbage.

On a write, the controller first bumps the line's counter and requests the pad. When the pad returns, it XORs the pad onto the plaintext and streams the ciphertext out as eight 32-bit beats. On a read, the pad request and the beat fetch start in the same cycle and run side by side. Decryption then costs one XOR once both have arrived. The lowest-numbered lines are treated as read-only: they keep no counter and their seed carries a zero counter field. Only one line transaction is in flight at a time.

Top module: `line_pad_crypt`

## Requirements
- R1: The pad seed is 128 bits laid out as {counter[15:0] in bits 127:112, line index[3:0] in bits 111:108, RAND_PAD[107:0] in bits 107:0}. It is held stable while the pad request waits for ready.
- R2: A write to a writable line adds 1 to that line's counter, and the seed of that write carries the new value. The request to the pad generator goes out before any memory beat of the write.
- R3: The ciphertext stored for a write equals plaintext XOR line pad. A read returns the fetched line XOR the pad built from the line's current counter, so an untouched line reads back its plaintext.
- R4: With the default 128-bit pad, the line pad is {pad, pad}: both 128-bit halves of a line are masked by the same pad. PAD_W=256 applies one 256-bit pad instead.
- R5: For a read, the pad request and the first memory beat request are both asserted in the cycle after the request is accepted.
- R6: A line moves as 8 beats, in ascending order. Beat k carries line bits 32k+31:32k at word address {line, k[2:0]}. A beat's address and data stay stable until mem_req_ready.
- R7: Lines with index below RO_LINES (default 4) are read-only. Their seed counter field is always 0 and a write to them changes no counter.
- R8: Only one transaction is outstanding. req_ready drops in the cycle after acceptance and returns in the cycle after the single-cycle resp_valid pulse. A write response comes only after all 8 beats have been accepted.
- R9: A read response comes only after both the pad response and all 8 read beats have arrived, whatever their order.
- R10: After reset, req_ready is high, no request is driven on either side and every counter is 0, so the first write to a writable line uses counter 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cache line request valid |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 = line write, 0 = line read |
| req_line | input | 4 | Line index |
| req_wdata | input | 256 | Plaintext line for writes |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 256 | Decrypted line (valid with resp_valid after a read) |
| pad_req_valid | output | 1 | Seed valid toward the pad generator |
| pad_req_ready | input | 1 | Pad generator accepts the seed |
| pad_req_data | output | 128 | Pad seed |
| pad_rsp_valid | input | 1 | Pad returned |
| pad_rsp_data | input | 128 | Pad value |
| mem_req_valid | output | 1 | Beat request valid |
| mem_req_ready | input | 1 | Memory accepts the beat request |
| mem_req_write | output | 1 | 1 = beat write, 0 = beat read |
| mem_req_addr | output | 7 | Word address {line, beat} |
| mem_req_wdata | output | 32 | Ciphertext beat for writes |
| mem_rsp_valid | input | 1 | Read beat returned (in request order) |
| mem_rsp_data | input | 32 | Read beat data |

## Verification
A counter that is off by one, or that a read-only line is allowed to move, shows up in the very next pad seed captured at the generator port, and in the ciphertext of that same write. The bench checks both against its own per-line counters after every write. A beat slot mapped wrongly corrupts a single 32-bit word. This shows in the memory image as soon as the write finishes and in the data returned by the next read of that line. A control fault that responds before the last beat or pad has arrived shows up at the response pulse: the bench compares the counts of beats and pads observed at that moment. Replay and relocation are staged by rewriting the bench memory, and the bench checks that the returned line equals the tampered ciphertext XOR the current pad.

// File: rtl/lpad_pkg.sv
package lpad_pkg;

    localparam int LINE_W     = 256;
    localparam int BEAT_W     = 32;
    localparam int BEATS      = LINE_W / BEAT_W;
    localparam int BEAT_IDX_W = $clog2(BEATS);
    localparam int PAD_IN_W   = 128;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WPAD,
        ST_WMEM,
        ST_RWAIT,
        ST_RESP
    } ctl_state_e;

    function automatic logic [BEAT_W-1:0] beat_of(input logic [LINE_W-1:0] line,
                                                  input logic [BEAT_IDX_W-1:0] idx);
        return line[int'(idx)*BEAT_W +: BEAT_W];
    endfunction

endpackage

// File: rtl/lpad_ctr_table.sv
module lpad_ctr_table #(
    parameter int LIDX_W   = 4,
    parameter int RO_LINES = 4,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LIDX_W-1:0] rd_line,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic              rd_ro,
    input  logic              bump
);
    localparam int NLINES = 1 << LIDX_W;
    localparam int NRW    = NLINES - RO_LINES;

    logic [CNT_W-1:0] cnt_q [NRW];

    assign rd_ro = int'(rd_line) < RO_LINES;

    // writable lines only; read-only lines own no storage
    always_comb begin
        rd_cnt = '0;
        for (int i = 0; i < NRW; i++) begin
            if (int'(rd_line) == i + RO_LINES) rd_cnt = cnt_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NRW; i++) cnt_q[i] <= '0;
        end else if (bump) begin
            for (int i = 0; i < NRW; i++) begin
                if (int'(rd_line) == i + RO_LINES) cnt_q[i] <= cnt_q[i] + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/lpad_pad_client.sv
module lpad_pad_client import lpad_pkg::*; #(
    parameter int PAD_W = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [PAD_IN_W-1:0] seed_in,
    output logic                pad_req_valid,
    input  logic                pad_req_ready,
    output logic [PAD_IN_W-1:0] pad_req_data,
    input  logic                pad_rsp_valid,
    input  logic [PAD_W-1:0]    pad_rsp_data,
    output logic                done,
    output logic [LINE_W-1:0]   line_pad
);
    logic                req_q, wait_q, done_q;
    logic [PAD_IN_W-1:0] seed_q;
    logic [PAD_W-1:0]    pad_q;

    assign pad_req_valid = req_q;
    assign pad_req_data  = seed_q;
    assign done          = done_q;

    generate
        if (PAD_W == LINE_W) begin : g_wide
            assign line_pad = pad_q;
        end else begin : g_repeat
            assign line_pad = {(LINE_W / PAD_W){pad_q}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            wait_q <= 1'b0;
            done_q <= 1'b0;
            seed_q <= '0;
            pad_q  <= '0;
        end else if (start) begin
            req_q  <= 1'b1;
            wait_q <= 1'b0;
            done_q <= 1'b0;
            seed_q <= seed_in;
        end else begin
            if (req_q && pad_req_ready) begin
                req_q  <= 1'b0;
                wait_q <= 1'b1;
            end
            if (wait_q && pad_rsp_valid) begin
                wait_q <= 1'b0;
                done_q <= 1'b1;
                pad_q  <= pad_rsp_data;
            end
        end
    end

endmodule

// File: rtl/lpad_beat_engine.sv
module lpad_beat_engine import lpad_pkg::*; #(
    parameter int LIDX_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         write,
    input  logic [LIDX_W-1:0]            line,
    input  logic [LINE_W-1:0]            wline,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic                         mem_req_write,
    output logic [LIDX_W+BEAT_IDX_W-1:0] mem_req_addr,
    output logic [BEAT_W-1:0]            mem_req_wdata,
    input  logic                         mem_rsp_valid,
    input  logic [BEAT_W-1:0]            mem_rsp_data,
    output logic                         done,
    output logic [LINE_W-1:0]            rline
);
    localparam logic [BEAT_IDX_W:0] LAST = (BEAT_IDX_W + 1)'(BEATS - 1);

    logic                  active_q, wr_q, done_q;
    logic [LIDX_W-1:0]     line_q;
    logic [LINE_W-1:0]     buf_q;
    logic [BEAT_IDX_W:0]   issue_q, recv_q;
    logic                  issuing;

    assign issuing       = active_q && (issue_q <= LAST);
    assign mem_req_valid = issuing;
    assign mem_req_write = wr_q;
    assign mem_req_addr  = {line_q, issue_q[BEAT_IDX_W-1:0]};
    assign mem_req_wdata = beat_of(buf_q, issue_q[BEAT_IDX_W-1:0]);
    assign done          = done_q;
    assign rline         = buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            done_q   <= 1'b0;
            line_q   <= '0;
            buf_q    <= '0;
            issue_q  <= '0;
            recv_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            wr_q     <= write;
            done_q   <= 1'b0;
            line_q   <= line;
            buf_q    <= wline;
            issue_q  <= '0;
            recv_q   <= '0;
        end else if (active_q) begin
            if (issuing && mem_req_ready) begin
                issue_q <= issue_q + 1'b1;
                if (wr_q && issue_q == LAST) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end
            if (!wr_q && mem_rsp_valid) begin
                buf_q[int'(recv_q[BEAT_IDX_W-1:0])*BEAT_W +: BEAT_W] <= mem_rsp_data;
                recv_q <= recv_q + 1'b1;
                if (recv_q == LAST) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/line_pad_crypt.sv
module line_pad_crypt import lpad_pkg::*; #(
    parameter int                  LIDX_W   = 4,
    parameter int                  RO_LINES = 4,
    parameter int                  CNT_W    = 16,
    parameter int                  PAD_W    = 128,
    parameter logic [PAD_IN_W-1:0] RAND_PAD = 128'h3C6E_F372_A54F_F53A_510E_527F_9B05_688C
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [LIDX_W-1:0]            req_line,
    input  logic [LINE_W-1:0]            req_wdata,
    output logic                         resp_valid,
    output logic [LINE_W-1:0]            resp_rdata,
    output logic                         pad_req_valid,
    input  logic                         pad_req_ready,
    output logic [PAD_IN_W-1:0]          pad_req_data,
    input  logic                         pad_rsp_valid,
    input  logic [PAD_W-1:0]             pad_rsp_data,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic                         mem_req_write,
    output logic [LIDX_W+BEAT_IDX_W-1:0] mem_req_addr,
    output logic [BEAT_W-1:0]            mem_req_wdata,
    input  logic                         mem_rsp_valid,
    input  logic [BEAT_W-1:0]            mem_rsp_data
);
    localparam int FILL_W = PAD_IN_W - CNT_W - LIDX_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [LIDX_W-1:0] line;
        logic [FILL_W-1:0] fill;
    } seed_t;

    ctl_state_e        state_q;
    logic [LINE_W-1:0] ptext_q, rdata_q;
    logic [LIDX_W-1:0] line_q;
    logic              accept;
    logic [CNT_W-1:0]  tbl_cnt;
    logic              tbl_ro;
    seed_t             seed;
    logic              pad_done, beat_done;
    logic [LINE_W-1:0] line_pad, beat_rline;
    logic              beat_start, beat_write;
    logic [LIDX_W-1:0] beat_line;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign resp_valid = (state_q == ST_RESP);
    assign resp_rdata = rdata_q;

    always_comb begin
        seed.cnt  = tbl_ro ? '0 : (req_write ? tbl_cnt + CNT_W'(1) : tbl_cnt);
        seed.line = req_line;
        seed.fill = RAND_PAD[FILL_W-1:0];
    end

    lpad_ctr_table #(
        .LIDX_W  (LIDX_W),
        .RO_LINES(RO_LINES),
        .CNT_W   (CNT_W)
    ) ctr_i (
        .clk    (clk),
        .rst    (rst),
        .rd_line(req_line),
        .rd_cnt (tbl_cnt),
        .rd_ro  (tbl_ro),
        .bump   (accept && req_write && !tbl_ro)
    );

    lpad_pad_client #(.PAD_W(PAD_W)) pad_i (
        .clk          (clk),
        .rst          (rst),
        .start        (accept),
        .seed_in      (seed),
        .pad_req_valid(pad_req_valid),
        .pad_req_ready(pad_req_ready),
        .pad_req_data (pad_req_data),
        .pad_rsp_valid(pad_rsp_valid),
        .pad_rsp_data (pad_rsp_data),
        .done         (pad_done),
        .line_pad     (line_pad)
    );

    assign beat_start = (accept && !req_write) || (state_q == ST_WPAD && pad_done);
    assign beat_write = (state_q == ST_WPAD);
    assign beat_line  = (state_q == ST_IDLE) ? req_line : line_q;

    lpad_beat_engine #(.LIDX_W(LIDX_W)) beat_i (
        .clk          (clk),
        .rst          (rst),
        .start        (beat_start),
        .write        (beat_write),
        .line         (beat_line),
        .wline        (ptext_q ^ line_pad),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write),
        .mem_req_addr (mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .done         (beat_done),
        .rline        (beat_rline)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptext_q <= '0;
            rdata_q <= '0;
            line_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    line_q  <= req_line;
                    ptext_q <= req_wdata;
                    state_q <= req_write ? ST_WPAD : ST_RWAIT;
                end
                ST_WPAD:  if (pad_done) state_q <= ST_WMEM;
                ST_WMEM:  if (beat_done) state_q <= ST_RESP;
                ST_RWAIT: if (pad_done && beat_done) begin
                    rdata_q <= beat_rline ^ line_pad;
                    state_q <= ST_RESP;
                end
                ST_RESP:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/line_pad_crypt_chk.sv
module line_pad_crypt_chk import lpad_pkg::*; #(
    parameter int LIDX_W = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic                         req_write,
    input logic                         resp_valid,
    input logic                         pad_req_valid,
    input logic                         pad_req_ready,
    input logic [PAD_IN_W-1:0]          pad_req_data,
    input logic                         mem_req_valid,
    input logic                         mem_req_ready,
    input logic                         mem_req_write,
    input logic [LIDX_W+BEAT_IDX_W-1:0] mem_req_addr,
    input logic [BEAT_W-1:0]            mem_req_wdata
);
    // R1
    seed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pad_req_valid && !pad_req_ready |=> pad_req_valid && $stable(pad_req_data));

    // R2
    write_pad_first_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_write |=> pad_req_valid && !mem_req_valid);

    // R5
    read_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !req_write |=> pad_req_valid && mem_req_valid && !mem_req_write);

    // R6
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_write));

    // R8
    single_txn_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R8
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid && req_ready);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid && !pad_req_valid && !resp_valid);

endmodule

bind line_pad_crypt line_pad_crypt_chk #(.LIDX_W(LIDX_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .resp_valid   (resp_valid),
    .pad_req_valid(pad_req_valid),
    .pad_req_ready(pad_req_ready),
    .pad_req_data (pad_req_data),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata)
);

// File: tb/line_pad_crypt_tb_top.sv
module line_pad_crypt_tb_top;

    localparam logic [127:0] RAND_C = 128'h3C6E_F372_A54F_F53A_510E_527F_9B05_688C;
    localparam logic [127:0] KEY_C  = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    localparam logic [127:0] MULT_C = 128'hD6E8_FEB8_6659_FD93_9E37_79B9_7F4A_7C15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]   req_line = '0;
    logic [255:0] req_wdata = '0;
    logic         req_ready, resp_valid;
    logic [255:0] resp_rdata;
    logic         pad_req_valid, pad_req_ready, pad_rsp_valid;
    logic [127:0] pad_req_data, pad_rsp_data;
    logic         mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
    logic [6:0]   mem_req_addr;
    logic [31:0]  mem_req_wdata, mem_rsp_data;

    line_pad_crypt dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_line(req_line), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .pad_req_valid(pad_req_valid), .pad_req_ready(pad_req_ready), .pad_req_data(pad_req_data),
        .pad_rsp_valid(pad_rsp_valid), .pad_rsp_data(pad_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int tests = 0, fails = 0;

    // ---------- reference functions ----------
    function automatic logic [127:0] mix(input logic [127:0] x);
        logic [127:0] r;
        r = x ^ KEY_C;
        for (int i = 0; i < 3; i++) begin
            r = r ^ (r >> 29);
            r = r * MULT_C;
            r = {r[64:0], r[127:65]};
        end
        return r;
    endfunction

    function automatic logic [127:0] seed_of(input int cnt, input int line);
        return {cnt[15:0], line[3:0], RAND_C[107:0]};
    endfunction

    function automatic logic [255:0] lpad_of(input logic [127:0] s);
        logic [127:0] p;
        p = mix(s);
        return {p, p};
    endfunction

    // ---------- memory and pad generator models ----------
    logic [31:0]  mem [128];
    int           rdq [$];
    logic [7:0]   alog [$];       // {write, addr}
    int           rsp_beats = 0, pad_rsps = 0, pads_seen = 0, pd_cnt = 0;
    logic [127:0] pd_in, last_seed;
    logic         poke_go = 1'b0;
    int           poke_line = 0;
    logic [255:0] poke_val = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 128; k++) mem[k] <= '0;
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_req_ready <= ($urandom % 4) != 0;
            mem_rsp_valid <= 1'b0;
            if (mem_rsp_valid) rsp_beats <= rsp_beats + 1;
            if (mem_req_valid && mem_req_ready) begin
                alog.push_back({mem_req_write, mem_req_addr});
                if (mem_req_write) mem[int'(mem_req_addr)] <= mem_req_wdata;
                else rdq.push_back(int'(mem_req_addr));
            end
            if (rdq.size() > 0 && ($urandom % 2) == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[rdq[0]];
                void'(rdq.pop_front());
            end
            if (poke_go)
                for (int k = 0; k < 8; k++) mem[poke_line*8+k] <= poke_val[32*k +: 32];
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            pad_req_ready <= 1'b0;
            pad_rsp_valid <= 1'b0;
            pad_rsp_data  <= '0;
            pd_cnt        <= 0;
        end else begin
            pad_req_ready <= ($urandom % 3) != 0;
            pad_rsp_valid <= 1'b0;
            if (pad_rsp_valid) pad_rsps <= pad_rsps + 1;
            if (pad_req_valid && pad_req_ready) begin
                pd_in     <= pad_req_data;
                last_seed <= pad_req_data;
                pads_seen <= pads_seen + 1;
                pd_cnt    <= 2 + int'($urandom % 9);
            end else if (pd_cnt > 0) begin
                pd_cnt <= pd_cnt - 1;
                if (pd_cnt == 1) begin
                    pad_rsp_valid <= 1'b1;
                    pad_rsp_data  <= mix(pd_in);
                end
            end
        end
    end

    function automatic logic [255:0] mem_line(input int l);
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[32*k +: 32] = mem[l*8+k];
        return v;
    endfunction

    // ---------- checking helpers ----------
    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int           bcnt  [16];
    logic [255:0] plain [16];
    bit           clean [16];

    task automatic poke(input int l, input logic [255:0] v);
        @(negedge clk);
        poke_line = l; poke_val = v; poke_go = 1'b1;
        @(negedge clk);
        poke_go = 1'b0;
    endtask

    task automatic send(input bit w, input int l, input logic [255:0] d, output logic [255:0] rd);
        int a0, r0, p0, lat;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_line = l[3:0]; req_wdata = d;
        while (!req_ready) @(negedge clk);
        a0 = alog.size(); r0 = rsp_beats; p0 = pad_rsps;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy after accept", {255'd0, req_ready}, 256'd0);
        if (!w) chk("R5 pad and fetch together", {254'd0, pad_req_valid, mem_req_valid}, 256'd3);
        else    chk("R2 pad before beats", {254'd0, pad_req_valid, mem_req_valid}, 256'd2);
        lat = 0;
        while (!resp_valid && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
        if (!resp_valid) begin
            fails++; tests++;
            $display("FAIL R8 no response actual=0 expected=1");
        end
        rd = resp_rdata;
        if (w) begin
            chk("R8 all write beats before resp", 256'(alog.size() - a0), 256'd8);
        end else begin
            chk("R9 read beats before resp", 256'(rsp_beats - r0), 256'd8);
            chk("R9 pad before resp", 256'(pad_rsps - p0), 256'd1);
        end
        for (int k = 0; k < 8 && a0 + k < alog.size(); k++)
            chk("R6 beat order", 256'(alog[a0+k]), 256'({w, l[3:0], k[2:0]}));
        @(negedge clk);
        chk("R8 free after resp", {254'd0, req_ready, resp_valid}, 256'd2);
    endtask

    task automatic do_write(input int l, input logic [255:0] d);
        logic [255:0] rd, ct, pad;
        int c;
        c = (l < 4) ? 0 : bcnt[l] + 1;
        send(1'b1, l, d, rd);
        if (l >= 4) bcnt[l] = c;
        chk(l < 4 ? "R7 read-only seed" : "R1 R2 write seed", 256'(last_seed), 256'(seed_of(c, l)));
        pad = lpad_of(seed_of(c, l));
        ct  = mem_line(l);
        chk("R3 stored ciphertext", ct, d ^ pad);
        chk("R4 halves share pad", 256'(ct[255:128] ^ d[255:128]), 256'(ct[127:0] ^ d[127:0]));
        plain[l] = d; clean[l] = 1'b1;
    endtask

    task automatic do_read(input int l);
        logic [255:0] rd, exp;
        send(1'b0, l, '0, rd);
        chk("R1 read seed", 256'(last_seed), 256'(seed_of(l < 4 ? 0 : bcnt[l], l)));
        exp = mem_line(l) ^ lpad_of(seed_of(l < 4 ? 0 : bcnt[l], l));
        chk("R3 read data", rd, exp);
        if (clean[l]) chk("R3 plaintext recovered", rd, plain[l]);
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    // ---------- watchdog ----------
    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------- stimulus ----------
    initial begin
        logic [255:0] old_ct, rd;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin bcnt[i] = 0; plain[i] = '0; clean[i] = 1'b0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        chk("R10 reset outputs", {252'd0, req_ready, resp_valid, mem_req_valid, pad_req_valid}, 256'd8);

        // R10 first write uses counter 1; R6 pattern
        do_write(5, {8{32'hA5A5_0000}} | 256'h0706_0504_0302_0100);
        do_read(5);
        do_write(5, '1);                 // R2 counter 2
        do_read(5);
        do_write(15, '0);                // top line, all-zero plaintext
        do_read(15);

        // R7 read-only line: two writes keep counter field 0
        do_write(2, 256'h1234);
        do_write(2, 256'h5678);
        do_read(2);
        do_read(0);                      // never written read-only line

        // R3 replay: restore older ciphertext after a newer write
        old_ct = mem_line(5);
        do_write(5, 256'hC0FFEE);
        poke(5, old_ct); clean[5] = 1'b0;
        do_read(5);
        chk("R3 replay not accepted", {255'd0, (mem_line(5) ^ lpad_of(seed_of(bcnt[5], 5))) == plain[5]}, 256'd0);

        // R3 relocation: copy line 15 onto line 6
        do_write(6, 256'hBEEF);
        poke(6, mem_line(15)); clean[6] = 1'b0;
        send(1'b0, 6, '0, rd);
        chk("R3 relocation garbles", {255'd0, rd == '0}, 256'd0);

        // random mix
        for (int n = 0; n < 80; n++) begin
            int l;
            l = int'($urandom % 16);
            if (($urandom % 2) == 1) do_write(l, rnd256());
            else do_read(l);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule